// File: doc/BRIEF.md
# Register Read-Port Arbiter with Broadcast

This block lets several function units share a single read port of a register file. Each cycle, every unit may ask for the port. A request is eligible only when the unit is active and its read flag is set. A fixed-priority picker chooses one eligible unit, and the lowest index wins. In that same cycle the winner's register selector is driven onto the port address, and the port enable is raised.

The register file answers one cycle later. The block holds a registered copy of each grant, called the delayed pick. The delayed pick raises that unit's go-read strobe and routes the port's read data onto that unit's operand output. The delayed pick also keeps the unit out of arbitration for the cycle in which its data is returning. A unit that keeps requesting therefore cannot win two cycles in a row, and a lower-priority unit gets the port in between.

The block has two addressing variants. In binary mode the selector is a register number, and the enable is a single bit. In one-hot mode the selector is a one-hot read-enable vector, and it drives the port enable directly. The block keeps no register storage and tracks no hazards.

Top module: `regrd_share`

## Requirements
- R1: While reset is high and right after it falls, every go-read output is 0 and every data output is zero. This holds even if requests were present during reset.
- R2: Requester i is eligible in a cycle only when its request, active and read-flag inputs are all 1 and its go-read output is 0 in that cycle.
- R3: Among the eligible requesters, the lowest index is granted. At most one requester is granted per cycle.
- R4: In a grant cycle, port_sel_o equals the granted requester's selector (bits [i*SEL_W +: SEL_W] of sel_i). With no grant, port_sel_o is zero.
- R5: The go-read output of a requester granted in cycle k is 1 in cycle k+1. It is 0 in any cycle that does not follow a grant to that requester.
- R6: A requester granted in cycle k is not granted in cycle k+1, even if it still requests. The next eligible requester by index is granted instead.
- R7: data_o slice i (bits [i*DATA_W +: DATA_W]) equals port_data_i while go_rd_o[i] is 1, and is zero otherwise.
- R8: In binary mode (MODE = ADDR_BINARY), port_ren_o is 1 in bit 0 and zero in all higher bits during a grant cycle, and all zero otherwise. In one-hot mode (MODE = ADDR_ONEHOT), port_ren_o equals port_sel_o.
- R9: A request whose active or read-flag input is 0 produces no grant, no port enable and no later go-read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | N | Read request per requester |
| active_i | input | N | Unit-active bit per requester |
| rdflag_i | input | N | Read-flag per requester (the operand is really needed) |
| sel_i | input | N*SEL_W | Register selector per requester, packed by index |
| port_data_i | input | DATA_W | Read data from the register-file port, valid one cycle after enable |
| port_sel_o | output | SEL_W | Port address: the granted requester's selector, or zero |
| port_ren_o | output | SEL_W | Port enable: one-hot vector or a single bit 0, by mode |
| go_rd_o | output | N | Go-read strobe per requester (the delayed pick) |
| data_o | output | N*DATA_W | Operand output per requester, packed by index |

## Verification
The case hardest to reach from the ports is a high-priority unit that keeps requesting while a lower-priority unit waits. The mask from the delayed pick must interleave them, and the returning data must land on the unit whose strobe is raised, not on the one currently being granted. The stimulus holds all requests high for several cycles and changes port_data_i every cycle, so a one-cycle slip in data alignment shows up as a wrong value. A long pseudo-random run over the request, active and read-flag inputs then mixes masked, ineligible and back-to-back cases. A second instance in one-hot mode checks the enable variant against the same stimulus.

// File: rtl/rpa_pkg.sv
`timescale 1ns/1ps
package rpa_pkg;
  typedef enum logic {
    ADDR_BINARY = 1'b0,
    ADDR_ONEHOT = 1'b1
  } addr_mode_e;
endpackage

// File: rtl/rpa_picker.sv
`timescale 1ns/1ps
module rpa_picker #(
  parameter int N = 4
) (
  input  logic [N-1:0] pick_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);
  // seen[i] is high when some lower-index pick input is already set
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign seen[i+1]  = seen[i] | pick_i[i];
    assign grant_o[i] = pick_i[i] & ~seen[i];
  end

  assign any_o = seen[N];
endmodule

// File: rtl/rpa_selmux.sv
`timescale 1ns/1ps
module rpa_selmux
  import rpa_pkg::*;
#(
  parameter int         N     = 4,
  parameter int         SEL_W = 4,
  parameter addr_mode_e MODE  = ADDR_BINARY
) (
  input  logic [N-1:0]       grant_i,
  input  logic [N*SEL_W-1:0] sel_i,
  output logic [SEL_W-1:0]   port_sel_o,
  output logic [SEL_W-1:0]   port_ren_o
);
  logic [SEL_W-1:0] acc [N+1];
  assign acc[0] = '0;

  for (genvar i = 0; i < N; i++) begin : g_or
    assign acc[i+1] = acc[i] | (grant_i[i] ? sel_i[i*SEL_W +: SEL_W] : '0);
  end

  assign port_sel_o = acc[N];

  if (MODE == ADDR_ONEHOT) begin : g_onehot
    assign port_ren_o = acc[N];
  end else begin : g_binary
    assign port_ren_o = SEL_W'(|grant_i);
  end
endmodule

// File: rtl/rpa_fanout.sv
`timescale 1ns/1ps
module rpa_fanout #(
  parameter int N      = 4,
  parameter int DATA_W = 16
) (
  input  logic [N-1:0]        dpick_i,
  input  logic [DATA_W-1:0]   port_data_i,
  output logic [N*DATA_W-1:0] data_o
);
  for (genvar i = 0; i < N; i++) begin : g_lane
    assign data_o[i*DATA_W +: DATA_W] = dpick_i[i] ? port_data_i : '0;
  end
endmodule

// File: rtl/regrd_share.sv
`timescale 1ns/1ps
module regrd_share
  import rpa_pkg::*;
#(
  parameter int         N      = 4,
  parameter int         SEL_W  = 4,
  parameter int         DATA_W = 16,
  parameter addr_mode_e MODE   = ADDR_BINARY
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        req_i,
  input  logic [N-1:0]        active_i,
  input  logic [N-1:0]        rdflag_i,
  input  logic [N*SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0]   port_data_i,
  output logic [SEL_W-1:0]    port_sel_o,
  output logic [SEL_W-1:0]    port_ren_o,
  output logic [N-1:0]        go_rd_o,
  output logic [N*DATA_W-1:0] data_o
);
  logic [N-1:0] dpick;
  logic [N-1:0] elig;
  logic [N-1:0] raw_grant;
  logic         any_grant;
  logic [N-1:0] grant;

  // eligibility: request qualified by active and flag, masked by own delayed pick (R2)
  assign elig = req_i & active_i & rdflag_i & ~dpick;

  rpa_picker #(.N(N)) u_picker (
    .pick_i  (elig),
    .grant_o (raw_grant),
    .any_o   (any_grant)
  );

  assign grant = raw_grant & {N{any_grant}};

  // delayed pick: one register per requester, matches port read latency
  always_ff @(posedge clk) begin
    if (rst) dpick <= '0;
    else     dpick <= grant;
  end

  assign go_rd_o = dpick;

  rpa_selmux #(.N(N), .SEL_W(SEL_W), .MODE(MODE)) u_selmux (
    .grant_i    (grant),
    .sel_i      (sel_i),
    .port_sel_o (port_sel_o),
    .port_ren_o (port_ren_o)
  );

  rpa_fanout #(.N(N), .DATA_W(DATA_W)) u_fanout (
    .dpick_i     (dpick),
    .port_data_i (port_data_i),
    .data_o      (data_o)
  );

  // R3: never more than one grant
  a_r3_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R9 and R3: an eligible requester always wins something
  a_r9_eligible_served: assert property (@(posedge clk) disable iff (rst)
    (|elig) |-> (|grant));

  // R6: the same requester is not granted on consecutive cycles
  a_r6_no_regrant: assert property (@(posedge clk) disable iff (rst)
    (|grant) |=> ((grant & $past(grant)) == '0));

  // R4: port stays quiet without a grant
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (grant == '0) |-> (port_sel_o == '0 && port_ren_o == '0));

  // R5: a grant is followed by a go-read strobe
  a_r5_go_follows: assert property (@(posedge clk) disable iff (rst)
    (|grant) |=> (|go_rd_o));

  // R5: strobes never overlap
  a_r5_go_onehot0: assert property (@(posedge clk) disable iff (rst)
    $onehot0(go_rd_o));
endmodule

// File: tb/regrd_share_bench.sv
`timescale 1ns/1ps
module regrd_share_bench;
  import rpa_pkg::*;
  localparam int N  = 4;
  localparam int SW = 4;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst;
  logic [N-1:0]  req, act, flg;
  logic [N*SW-1:0] sel;
  logic [DW-1:0] pdata;
  logic [SW-1:0] psel, pren, psel_oh, pren_oh;
  logic [N-1:0]  go, go_oh;
  logic [N*DW-1:0] dout, dout_oh;

  regrd_share #(.N(N), .SEL_W(SW), .DATA_W(DW), .MODE(ADDR_BINARY)) u_regrd_share (
    .clk(clk), .rst(rst), .req_i(req), .active_i(act), .rdflag_i(flg),
    .sel_i(sel), .port_data_i(pdata), .port_sel_o(psel), .port_ren_o(pren),
    .go_rd_o(go), .data_o(dout));

  regrd_share #(.N(N), .SEL_W(SW), .DATA_W(DW), .MODE(ADDR_ONEHOT)) u_regrd_share_oh (
    .clk(clk), .rst(rst), .req_i(req), .active_i(act), .rdflag_i(flg),
    .sel_i(sel), .port_data_i(pdata), .port_sel_o(psel_oh), .port_ren_o(pren_oh),
    .go_rd_o(go_oh), .data_o(dout_oh));

  typedef struct {
    logic [N-1:0] go;
    string        tag;
  } item_t;
  item_t q[$];

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [N-1:0] model_go = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] actual, input logic [63:0] expect_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, actual, expect_v);
    end
  endtask

  // monitor: pops the expectation pushed one cycle earlier
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        chk(go == it.go, {it.tag, " R5"}, "go_rd_o", 64'(go), 64'(it.go));
        chk(go_oh == it.go, {it.tag, " R5 onehot"}, "go_rd_o", 64'(go_oh), 64'(it.go));
        for (int i = 0; i < N; i++) begin
          logic [DW-1:0] e;
          e = it.go[i] ? pdata : '0;
          chk(dout[i*DW +: DW] == e, "R7", $sformatf("data_o[%0d]", i),
              64'(dout[i*DW +: DW]), 64'(e));
        end
      end
    end
  end

  // driver: applies one cycle of stimulus, checks port side, pushes expectation
  task automatic drive(input logic [N-1:0] r, input logic [N-1:0] a,
                       input logic [N-1:0] f, input string tag);
    logic [N-1:0] el, g;
    logic [SW-1:0] es;
    @(negedge clk);
    req = r; act = a; flg = f;
    cyc++;
    pdata = 16'hA000 + 16'(cyc * 37);
    #2;
    el = r & a & f & ~model_go;
    g = '0; es = '0;
    for (int i = N - 1; i >= 0; i--)
      if (el[i]) g = N'(1) << i;
    for (int i = 0; i < N; i++)
      if (g[i]) es = sel[i*SW +: SW];
    chk(psel == es, {tag, " R4 R3"}, "port_sel_o", 64'(psel), 64'(es));
    chk(pren == SW'(g != '0), {tag, " R8 binary"}, "port_ren_o", 64'(pren), 64'(g != '0));
    chk(pren_oh == es, {tag, " R8 onehot"}, "port_ren_o", 64'(pren_oh), 64'(es));
    q.push_back('{go: g, tag: tag});
    model_go = g;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    rst = 1'b1; req = '1; act = '1; flg = '1; pdata = '0;
    sel = {4'h8, 4'h4, 4'h2, 4'h1};
    repeat (3) @(negedge clk);
    #1;
    chk(go == '0, "R1", "go_rd_o in reset", 64'(go), 0);
    chk(dout == '0, "R1", "data_o in reset", 64'(dout), 0);
    req = '0;
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(go == '0, "R1", "go_rd_o after reset", 64'(go), 0);
    chk(dout == '0, "R1", "data_o after reset", 64'(dout), 0);

    // single requester
    drive(4'b0100, 4'hF, 4'hF, "R3 single");
    drive(4'b0000, 4'hF, 4'hF, "R5 idle");
    // two requesters, lowest wins then the other
    drive(4'b1010, 4'hF, 4'hF, "R3 pair");
    drive(4'b1010, 4'hF, 4'hF, "R6 pair");
    drive(4'b0000, 4'hF, 4'hF, "R5 idle");
    // everyone requests continuously: alternation via delayed-pick mask
    for (int k = 0; k < 6; k++) drive(4'b1111, 4'hF, 4'hF, "R6 all");
    drive(4'b0000, 4'hF, 4'hF, "R5 idle");
    // inactive or flag low: ignored
    drive(4'b1111, 4'b0000, 4'hF, "R9 inactive");
    drive(4'b1111, 4'hF, 4'b0000, "R9 noflag");
    drive(4'b0011, 4'b1110, 4'b1101, "R2 mixed");
    drive(4'b0000, 4'hF, 4'hF, "R9 idle");
    // non one-hot selectors
    sel = {4'hC, 4'h9, 4'h6, 4'h3};
    drive(4'b1100, 4'hF, 4'hF, "R4 binsel");
    drive(4'b1100, 4'hF, 4'hF, "R4 binsel");
    drive(4'b1100, 4'hF, 4'hF, "R6 binsel");
    // pseudo-random mix
    lfsr = 16'hACE1;
    for (int k = 0; k < 80; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive(lfsr[3:0] | lfsr[11:8], lfsr[7:4] | 4'b0101, lfsr[15:12] | 4'b1010, "R2 random");
    end
    drive(4'b0000, 4'hF, 4'hF, "R5 flush");
    drive(4'b0000, 4'hF, 4'hF, "R5 flush");
    @(negedge clk);
    #2;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule